// File: doc/BRIEF.md
# Packet-mode I2C header decoder

This block sits between the transmit word FIFO of a packet-mode I2C master and its bit-level bus engine. Software pushes each transfer into the FIFO as three 32-bit header words, followed by payload words when the transfer is a write. The decoder reads the header words in order and checks that the first one is tagged as an I2C packet. It then presents one transfer descriptor to the bus engine. The descriptor carries the controller and packet identifiers, the byte count, the direction, the addressing mode and address, the option flags and the action to take at the end of the transfer.

For a write, the payload words are split into a byte stream, least significant byte first. Bytes in the last word that lie past the byte count are dropped. For a read, no payload is expected. In both cases the decoder waits for the engine's done pulse before it fetches the next header. If a packet is malformed, the decoder latches an error and swallows FIFO words until a flush.

Top module: `pkt_hdr_decoder`

## Requirements
- R1: After reset or a one-cycle `flush`, `desc_valid`, `byte_valid` and `proto_err` are low and `wd_ready` is high, waiting for header word 0.
- R2: If header word 0 has bit 4 clear, `proto_err` rises on the next cycle. From then on every offered word is accepted and discarded, and no descriptor appears, until `flush`.
- R3: `desc_hdr_size` is word 0 bits [29:28], `desc_pkt_id` is word 0 bits [23:16] and `desc_ctrl_id` is word 0 bits [15:12].
- R4: `desc_byte_cnt` equals word 1 bits [11:0] plus one, so a field of 0 means one byte.
- R5: From word 2: bit 22 gives `desc_hs`, bit 21 `desc_nack_cont`, bit 20 `desc_start_byte`, bit 19 `desc_read`, bit 18 `desc_ten_bit` and bit 17 `desc_irq_en`.
- R6: When bit 18 of word 2 is clear, `desc_addr` is word 2 bits [7:1] zero-extended. When it is set, `desc_addr` is word 2 bits [9:0].
- R7: `desc_end` is 2 (continue, no start and no stop) when word 2 bit 15 is set, else 1 (repeated start) when bit 16 is set, else 0 (stop). Bit 15 wins when both bits are set.
- R8: The descriptor appears the cycle after word 2 is taken. It holds with stable fields until `desc_ready`, and no word is accepted while it waits.
- R9: For a write, each payload word yields bytes from bits [7:0] upward. `byte_last` marks byte number `desc_byte_cnt`, and the bytes after it in that word are discarded. A new payload word is taken only after the bytes of the current word have been used.
- R10: For a read, no payload word is accepted after the descriptor handshake. `wd_ready` stays low until `eng_done`, and the next header is then taken.
- R11: After the last write byte, `wd_ready` stays low until `eng_done`. `eng_done` in any other phase has no effect.
- R12: While `byte_valid` is high and `byte_ready` is low, `byte_valid`, `byte_data` and `byte_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous restart of parsing, clears the error |
| wd_valid | input | 1 | FIFO word available |
| wd_data | input | 32 | FIFO word |
| wd_ready | output | 1 | Word taken when high with wd_valid |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Engine accepts descriptor |
| desc_hdr_size | output | 2 | Header size field |
| desc_pkt_id | output | 8 | Packet identifier |
| desc_ctrl_id | output | 4 | Controller identifier |
| desc_byte_cnt | output | 13 | Payload bytes, 1 to 4096 |
| desc_read | output | 1 | Read transfer |
| desc_ten_bit | output | 1 | 10-bit addressing |
| desc_addr | output | 10 | Slave address |
| desc_end | output | 2 | End action: 0 stop, 1 repeated start, 2 continue |
| desc_hs | output | 1 | High-speed mode |
| desc_nack_cont | output | 1 | Carry on after NACK |
| desc_start_byte | output | 1 | Send start byte |
| desc_irq_en | output | 1 | Interrupt on completion |
| byte_valid | output | 1 | Payload byte available |
| byte_ready | input | 1 | Engine accepts byte |
| byte_data | output | 8 | Payload byte |
| byte_last | output | 1 | Final payload byte |
| eng_done | input | 1 | Engine finished the transfer |
| proto_err | output | 1 | Malformed packet seen |

## Verification
The most telling symptom of a wrong internal state is `wd_ready`. If the header index or the phase slips, the ready level or the words taken diverge from the model within one cycle. A lost lane or a wrong remaining count shows up as the wrong `byte_data` or a misplaced `byte_last` on the very next byte. A wrong error latch is visible on `proto_err` and `desc_valid` in the cycle after the word that caused it. Because the bench model is compared every clock under random back-pressure and random done pulses, a phase that leaves too early or too late is reported in the cycle where it happens.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  localparam int HDR_WORD_W  = 32;
  localparam int LEN_FLD_W   = 12;
  localparam int CNT_W       = LEN_FLD_W + 1;
  localparam int ADDR_W      = 10;
  localparam int PROTO_BIT   = 4;
  localparam int BIT_HS      = 22;
  localparam int BIT_NACKC   = 21;
  localparam int BIT_SBYTE   = 20;
  localparam int BIT_RD      = 19;
  localparam int BIT_TEN     = 18;
  localparam int BIT_IE      = 17;
  localparam int BIT_RSTART  = 16;
  localparam int BIT_CONT    = 15;

  typedef enum logic [1:0] {
    END_STOP   = 2'd0,
    END_RSTART = 2'd1,
    END_CONT   = 2'd2
  } end_act_e;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic [1:0]        hdr_size;
    logic [7:0]        pkt_id;
    logic [3:0]        ctrl_id;
    logic [CNT_W-1:0]  byte_cnt;
    logic              hs;
    logic              nack_cont;
    logic              start_byte;
    logic              rd;
    logic              ten_bit;
    logic              irq_en;
    end_act_e          end_act;
    logic [ADDR_W-1:0] addr;
  } xfer_desc_t;
endpackage

// File: rtl/pkt_hdr_collect.sv
module pkt_hdr_collect
  import pkt_hdr_pkg::*;
#(
  parameter int WORD_W = HDR_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              en,
  input  logic              w_valid,
  input  logic [WORD_W-1:0] w_data,
  output logic              w_ready,
  output xfer_desc_t        desc_o,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic              err_o
);
  localparam int IDX_W = 2;

  logic [IDX_W-1:0] idx_q;
  logic             err_q;
  logic             dv_q;
  xfer_desc_t       desc_q;
  logic             take;
  logic             unused_hi;

  assign unused_hi  = &{w_data[WORD_W-1:30], w_data[27:24], w_data[14:12]};
  assign w_ready    = en && (err_q || !dv_q);
  assign take       = w_valid && w_ready && !err_q;
  assign desc_o     = desc_q;
  assign desc_valid = dv_q;
  assign err_o      = err_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      idx_q  <= '0;
      err_q  <= 1'b0;
      dv_q   <= 1'b0;
      desc_q <= '0;
    end else begin
      if (dv_q && desc_ready) dv_q <= 1'b0;
      if (take) begin
        case (idx_q)
          2'd0: begin
            if (!w_data[PROTO_BIT]) begin
              err_q <= 1'b1;
            end else begin
              desc_q.hdr_size <= w_data[29:28];
              desc_q.pkt_id   <= w_data[23:16];
              desc_q.ctrl_id  <= w_data[15:12];
              idx_q           <= 2'd1;
            end
          end
          2'd1: begin
            desc_q.byte_cnt <= {1'b0, w_data[LEN_FLD_W-1:0]} + CNT_W'(1);
            idx_q           <= 2'd2;
          end
          default: begin
            desc_q.hs         <= w_data[BIT_HS];
            desc_q.nack_cont  <= w_data[BIT_NACKC];
            desc_q.start_byte <= w_data[BIT_SBYTE];
            desc_q.rd         <= w_data[BIT_RD];
            desc_q.ten_bit    <= w_data[BIT_TEN];
            desc_q.irq_en     <= w_data[BIT_IE];
            if (w_data[BIT_CONT])        desc_q.end_act <= END_CONT;
            else if (w_data[BIT_RSTART]) desc_q.end_act <= END_RSTART;
            else                         desc_q.end_act <= END_STOP;
            if (w_data[BIT_TEN]) desc_q.addr <= w_data[ADDR_W-1:0];
            else                 desc_q.addr <= {3'b000, w_data[7:1]};
            dv_q  <= 1'b1;
            idx_q <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_byte_unpack.sv
module pkt_byte_unpack #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              w_valid,
  input  logic [WORD_W-1:0] w_data,
  output logic              w_ready,
  output logic              b_valid,
  output logic [BYTE_W-1:0] b_data,
  output logic              b_last,
  input  logic              b_ready,
  output logic              finish
);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              active_q;
  logic              bv_q;
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  rem_q;
  logic [BYTE_W-1:0] lane_byte [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  assign w_ready = active_q && !bv_q;
  assign b_valid = bv_q;
  assign b_data  = lane_byte[lane_q];
  assign b_last  = (rem_q == CNT_W'(1));
  assign finish  = bv_q && b_ready && b_last;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      active_q <= 1'b0;
      bv_q     <= 1'b0;
      lane_q   <= '0;
      rem_q    <= '0;
      word_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      bv_q     <= 1'b0;
      lane_q   <= '0;
      rem_q    <= start_cnt;
    end else if (w_valid && w_ready) begin
      word_q <= w_data;
      lane_q <= '0;
      bv_q   <= 1'b1;
    end else if (bv_q && b_ready) begin
      rem_q <= rem_q - CNT_W'(1);
      if (b_last) begin
        bv_q     <= 1'b0;
        active_q <= 1'b0;
      end else if (lane_q == LANE_W'(LANES - 1)) begin
        bv_q <= 1'b0;
      end else begin
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end
endmodule

// File: rtl/pkt_hdr_decoder.sv
module pkt_hdr_decoder
  import pkt_hdr_pkg::*;
#(
  parameter int WORD_W = HDR_WORD_W,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  output logic              wd_ready,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [1:0]        desc_hdr_size,
  output logic [7:0]        desc_pkt_id,
  output logic [3:0]        desc_ctrl_id,
  output logic [CNT_W-1:0]  desc_byte_cnt,
  output logic              desc_read,
  output logic              desc_ten_bit,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [1:0]        desc_end,
  output logic              desc_hs,
  output logic              desc_nack_cont,
  output logic              desc_start_byte,
  output logic              desc_irq_en,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_last,
  input  logic              eng_done,
  output logic              proto_err
);
  phase_e     phase_q;
  xfer_desc_t desc;
  logic       col_ready;
  logic       unp_ready;
  logic       unp_finish;
  logic       desc_fire;
  logic       unp_start;

  assign desc_fire = desc_valid && desc_ready;
  assign unp_start = desc_fire && !desc.rd;

  pkt_hdr_collect #(.WORD_W(WORD_W)) u_collect (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .en         (phase_q == PH_HDR),
    .w_valid    (wd_valid),
    .w_data     (wd_data),
    .w_ready    (col_ready),
    .desc_o     (desc),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .err_o      (proto_err)
  );

  pkt_byte_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .start     (unp_start),
    .start_cnt (desc.byte_cnt),
    .w_valid   (wd_valid && (phase_q == PH_DATA)),
    .w_data    (wd_data),
    .w_ready   (unp_ready),
    .b_valid   (byte_valid),
    .b_data    (byte_data),
    .b_last    (byte_last),
    .b_ready   (byte_ready),
    .finish    (unp_finish)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      phase_q <= PH_HDR;
    end else begin
      case (phase_q)
        PH_HDR:  if (desc_fire) phase_q <= desc.rd ? PH_WAIT : PH_DATA;
        PH_DATA: if (unp_finish) phase_q <= PH_WAIT;
        default: if (eng_done) phase_q <= PH_HDR;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_HDR:  wd_ready = col_ready;
      PH_DATA: wd_ready = unp_ready;
      default: wd_ready = 1'b0;
    endcase
  end

  assign desc_hdr_size   = desc.hdr_size;
  assign desc_pkt_id     = desc.pkt_id;
  assign desc_ctrl_id    = desc.ctrl_id;
  assign desc_byte_cnt   = desc.byte_cnt;
  assign desc_read       = desc.rd;
  assign desc_ten_bit    = desc.ten_bit;
  assign desc_addr       = desc.addr;
  assign desc_end        = desc.end_act;
  assign desc_hs         = desc.hs;
  assign desc_nack_cont  = desc.nack_cont;
  assign desc_start_byte = desc.start_byte;
  assign desc_irq_en     = desc.irq_en;
endmodule

// File: rtl/pkt_hdr_decoder_chk.sv
module pkt_hdr_decoder_chk #(
  parameter int CNT_W  = 13,
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [CNT_W-1:0]  desc_byte_cnt,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [1:0]        desc_end,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic [BYTE_W-1:0] byte_data,
  input logic              byte_last,
  input logic              proto_err
);
  p_flush_clear_r1: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!desc_valid && !byte_valid && !proto_err));

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (proto_err && !flush) |=> proto_err);

  p_no_desc_in_err_r2: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> !desc_valid);

  p_desc_hold_r8: assert property (@(posedge clk) disable iff (rst || flush)
    (desc_valid && !desc_ready) |=>
      (desc_valid && $stable({desc_byte_cnt, desc_addr, desc_end})));

  p_byte_hold_r12: assert property (@(posedge clk) disable iff (rst || flush)
    (byte_valid && !byte_ready) |=>
      (byte_valid && $stable(byte_data) && $stable(byte_last)));

  p_phase_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(desc_valid && byte_valid));
endmodule

bind pkt_hdr_decoder pkt_hdr_decoder_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .flush         (flush),
  .desc_valid    (desc_valid),
  .desc_ready    (desc_ready),
  .desc_byte_cnt (desc_byte_cnt),
  .desc_addr     (desc_addr),
  .desc_end      (desc_end),
  .byte_valid    (byte_valid),
  .byte_ready    (byte_ready),
  .byte_data     (byte_data),
  .byte_last     (byte_last),
  .proto_err     (proto_err)
);

// File: tb/pkt_hdr_decoder_test.sv
module pkt_hdr_decoder_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, flush = 1'b0;
  logic wd_valid = 1'b0, desc_ready = 1'b0, byte_ready = 1'b0, eng_done = 1'b0;
  logic [31:0] wd_data = '0;
  logic wd_ready, desc_valid, desc_read, desc_ten_bit, desc_hs, desc_nack_cont;
  logic desc_start_byte, desc_irq_en, byte_valid, byte_last, proto_err;
  logic [1:0] desc_hdr_size, desc_end;
  logic [7:0] desc_pkt_id, byte_data;
  logic [3:0] desc_ctrl_id;
  logic [12:0] desc_byte_cnt;
  logic [9:0] desc_addr;

  pkt_hdr_decoder uut (
    .clk(clk), .rst(rst), .flush(flush), .wd_valid(wd_valid), .wd_data(wd_data),
    .wd_ready(wd_ready), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_hdr_size(desc_hdr_size), .desc_pkt_id(desc_pkt_id), .desc_ctrl_id(desc_ctrl_id),
    .desc_byte_cnt(desc_byte_cnt), .desc_read(desc_read), .desc_ten_bit(desc_ten_bit),
    .desc_addr(desc_addr), .desc_end(desc_end), .desc_hs(desc_hs),
    .desc_nack_cont(desc_nack_cont), .desc_start_byte(desc_start_byte),
    .desc_irq_en(desc_irq_en), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_last(byte_last), .eng_done(eng_done), .proto_err(proto_err)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [31:0] wq[$];
  logic [15:0] rng = 16'hACE1;
  bit flush_req = 0, stop_in = 0;

  // Behavioural reference state
  int m_ph = 0, m_idx = 0, m_lane = 0, m_rem = 0, m_cnt = 0;
  bit m_err = 0, m_dv = 0, m_bv = 0, m_rd = 0, m_stall = 0;
  logic [31:0] m_w0 = '0, m_w1 = '0, m_word = '0;
  int e_hsz, e_pid, e_cid, e_end, e_addr;
  bit e_hs, e_nk, e_sb, e_ten, e_ie;

  function automatic bit mw();
    if (m_ph == 0) return m_err || !m_dv;
    if (m_ph == 1) return !m_bv;
    return 0;
  endfunction

  function automatic string ready_tag();
    if (m_ph == 0) return m_err ? "R2" : (m_dv ? "R8" : "R1");
    if (m_ph == 1) return "R9";
    return m_rd ? "R10" : "R11";
  endfunction

  always @(posedge clk) begin
    bit acc;
    acc = wd_valid && mw() && !rst && !flush;
    if (acc) void'(wq.pop_front());
    m_stall = m_bv && !byte_ready;
    if (rst || flush) begin
      m_ph = 0; m_idx = 0; m_err = 0; m_dv = 0; m_bv = 0; m_stall = 0;
    end else if (m_ph == 0) begin
      if (m_dv && desc_ready) begin
        m_dv = 0; m_ph = m_rd ? 2 : 1; m_rem = m_cnt; m_bv = 0;
      end else if (acc && !m_err) begin
        if (m_idx == 0) begin
          if (!wd_data[4]) m_err = 1;
          else begin m_w0 = wd_data; m_idx = 1; end
        end else if (m_idx == 1) begin
          m_w1 = wd_data; m_idx = 2;
        end else begin
          e_hsz = int'(m_w0[29:28]); e_pid = int'(m_w0[23:16]); e_cid = int'(m_w0[15:12]);
          m_cnt = int'(m_w1[11:0]) + 1;
          e_hs = wd_data[22]; e_nk = wd_data[21]; e_sb = wd_data[20];
          m_rd = wd_data[19]; e_ten = wd_data[18]; e_ie = wd_data[17];
          e_end = wd_data[15] ? 2 : (wd_data[16] ? 1 : 0);
          e_addr = e_ten ? int'(wd_data[9:0]) : int'(wd_data[7:1]);
          m_dv = 1; m_idx = 0;
        end
      end
    end else if (m_ph == 1) begin
      if (acc) begin
        m_word = wd_data; m_lane = 0; m_bv = 1;
      end else if (m_bv && byte_ready) begin
        if (m_rem == 1) begin m_bv = 0; m_ph = 2; end
        else if (m_lane == 3) m_bv = 0;
        else m_lane++;
        m_rem--;
      end
    end else if (eng_done) begin
      m_ph = 0;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(64'(wd_ready), 64'(mw()), ready_tag());
    chk(64'(desc_valid), 64'(m_dv), m_err ? "R2" : "R8");
    chk(64'(proto_err), 64'(m_err), "R2");
    chk(64'(byte_valid), 64'(m_bv), "R9");
    if (m_dv) begin
      chk(64'({desc_hdr_size, desc_pkt_id, desc_ctrl_id}),
          64'({2'(e_hsz), 8'(e_pid), 4'(e_cid)}), "R3");
      chk(64'(desc_byte_cnt), 64'(m_cnt), "R4");
      chk(64'({desc_hs, desc_nack_cont, desc_start_byte, desc_ten_bit, desc_irq_en}),
          64'({e_hs, e_nk, e_sb, e_ten, e_ie}), "R5");
      chk(64'(desc_read), 64'(m_rd), "R10");
      chk(64'(desc_addr), 64'(e_addr), "R6");
      chk(64'(desc_end), 64'(e_end), "R7");
    end
    if (m_bv) begin
      chk(64'(byte_data), 64'(m_word[m_lane*8 +: 8]), m_stall ? "R12" : "R9");
      chk(64'(byte_last), 64'(m_rem == 1), "R9");
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (!rst) compare();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    flush = flush_req;
    if (flush_req) wq.delete();
    wd_valid = !stop_in && (wq.size() > 0) && (rng[7:6] != 2'b00);
    wd_data = (wq.size() > 0) ? wq[0] : 32'h0;
    desc_ready = rng[0] | rng[1];
    byte_ready = rng[2] | rng[3];
    eng_done = rng[4] & rng[5];
  endtask

  function automatic logic [31:0] w0(int pid, int cid, bit proto);
    return (32'(1) << 28) | (32'(pid) << 16) | (32'(cid) << 12) | (32'(proto) << 4);
  endfunction

  task automatic wait_idle();
    int n = 0;
    do begin cycle(); n++; end
    while (!(wq.size() == 0 && m_ph == 0 && !m_dv && m_idx == 0) && n < 3000);
    if (n >= 3000) chk(64'(0), 64'(1), "watchdog");
  endtask

  initial begin
    repeat (3) cycle();
    rst = 1'b0;
    repeat (3) cycle();
    // R3 R4 R5 R6 R7 R9: 7-byte write, 7-bit address, stop, padding byte AA dropped
    wq.push_back(w0(8'h5A, 4'h3, 1)); wq.push_back(32'd6);
    wq.push_back((32'h50 << 1) | (32'd1 << 17));
    wq.push_back(32'h44332211); wq.push_back(32'hAA776655);
    wait_idle();
    // R6 R7: 4-byte write, 10-bit address, repeated start, high speed
    wq.push_back(w0(8'h01, 4'hF, 1)); wq.push_back(32'd3);
    wq.push_back((32'd1 << 22) | (32'd1 << 18) | (32'd1 << 16) | 32'h2A5);
    wq.push_back(32'hCAFEF00D);
    wait_idle();
    // R7: both end bits set gives continue; single byte; R5 flags
    wq.push_back(w0(8'hFF, 4'h0, 1)); wq.push_back(32'd0);
    wq.push_back((32'd1 << 21) | (32'd1 << 20) | (32'd1 << 16) | (32'd1 << 15) | (32'h7F << 1));
    wq.push_back(32'hDEADBEEF);
    // R10: read followed at once by a queued write
    wq.push_back(w0(8'h22, 4'h5, 1)); wq.push_back(32'd8);
    wq.push_back((32'd1 << 19) | (32'h33 << 1));
    wq.push_back(w0(8'h23, 4'h5, 1)); wq.push_back(32'd12);
    wq.push_back(32'h12 << 1);
    wq.push_back(32'h03020100); wq.push_back(32'h07060504);
    wq.push_back(32'h0B0A0908); wq.push_back(32'h5555550C);
    wait_idle();
    // R2: bad protocol bit, junk swallowed until flush
    wq.push_back(w0(8'h10, 4'h1, 0));
    wq.push_back(w0(8'h11, 4'h1, 1)); wq.push_back(32'd0); wq.push_back(32'h0);
    begin
      int n = 0;
      while (wq.size() > 0 && n < 500) begin cycle(); n++; end
    end
    repeat (5) cycle();
    flush_req = 1; cycle(); flush_req = 0;
    // R1: flush in the middle of a payload
    wq.push_back(w0(8'h30, 4'h2, 1)); wq.push_back(32'd7);
    wq.push_back(32'h21 << 1); wq.push_back(32'h9ABCDEF0);
    repeat (12) cycle();
    flush_req = 1; cycle(); flush_req = 0;
    repeat (3) cycle();
    // R9 R12: clean write after flush
    wq.push_back(w0(8'h31, 4'h2, 1)); wq.push_back(32'd5);
    wq.push_back(32'h21 << 1);
    wq.push_back(32'h04030201); wq.push_back(32'hEEFF0605);
    wait_idle();
    repeat (20) cycle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule